// File: doc/BRIEF.md
# Doubleword Realignment Staging Buffer

This block sits between the read half and the write half of a DMA engine whose data path is one doubleword (eight bytes) wide. A burst of 1 to 64 bytes is announced with its length, the byte offset of its first byte inside the first source beat, and the byte offset at which it must land inside the first destination beat. The block then accepts the source beats, keeps only the bytes that belong to the burst, and returns them as destination beats. Each returned beat carries per-byte write enables, so the write side can issue the data as is to a destination that need not be doubleword aligned.

Two banks of 72 bytes each are used alternately. While one bank is drained toward the destination, the other can already be filled from the source. Each bank holds 64 bytes for the longest burst, plus one doubleword of slack. The slack is needed because a 64-byte burst that starts at a high destination offset reaches byte 70 of its bank. A bank becomes ready when its last source beat has been accepted, and becomes free again once its last destination beat has been taken. Bursts are drained in the order in which they were filled.

Top module: `dw_realign_buf`

## Requirements
- R1: After reset, out_valid and in_ready are low, start_ready is high, bank_ready is 2'b00 and bank_empty is 2'b11.
- R2: A start accepted with length L and source offset S raises in_ready from the next cycle. in_ready stays high until exactly ceil((S+L)/8) beats have been taken with in_valid high, and then drops.
- R3: A start whose length is 0 or greater than 64 is ignored. No bank begins filling, in_ready stays low and start_ready stays high.
- R4: In input beat i, byte lane j (bits 8j+7:8j) holds burst byte k = 8i+j-S when 0 <= k < L. Burst byte k is delivered on lane (D+k) mod 8 of output beat (D+k) div 8, where D is the destination offset.
- R5: A burst produces exactly ceil((D+L)/8) output beats, and out_last is high on the final one only.
- R6: Enable bit j of output beat m is set exactly when 8m+j lies in [D, D+L-1]. The first beat therefore starts at lane D, and the last beat stops at the lane of the final byte.
- R7: A 1-byte burst produces one output beat with exactly one enable bit set, for every pair of offsets.
- R8: bank_ready for a bank rises in the cycle after its last input beat is accepted. It falls in the cycle after its last output beat is accepted (out_valid and out_ready high). out_valid is high exactly while the bank being drained is ready.
- R9: Fills alternate between the two banks. start_ready is high only when no fill is in progress and the next bank to fill is not ready, so a second burst can fill while the first drains.
- R10: Bursts leave in the order in which they were filled. The drain side moves to the other bank after each completed burst.
- R11: While out_valid is high and out_ready is low, out_valid, out_data and out_be hold their values.
- R12: bank_empty for a bank is high exactly when that bank is neither ready nor being filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Announce a new burst |
| start_len_i | input | 7 | Burst length in bytes, 1 to 64 |
| start_src_i | input | 3 | Source byte offset inside the first input beat |
| start_dst_i | input | 3 | Destination byte offset inside the first output beat |
| start_ready_o | output | 1 | A start is accepted this cycle if presented |
| in_valid_i | input | 1 | Source beat present |
| in_data_i | input | 64 | Source beat, byte lane j at bits 8j+7:8j |
| in_ready_o | output | 1 | Source beat is taken when valid |
| out_valid_o | output | 1 | Destination beat present |
| out_ready_i | input | 1 | Destination side takes the beat |
| out_data_o | output | 64 | Destination beat |
| out_be_o | output | 8 | Per-byte write enable of the destination beat |
| out_last_o | output | 1 | Final beat of the burst |
| bank_ready_o | output | 2 | Per bank: a complete burst is held |
| bank_empty_o | output | 2 | Per bank: neither ready nor filling |

## Verification
The bench runs every pairing of source and destination offset at the full 64-byte length. A design with only 64 bytes of storage, or with an off-by-one in the lane arithmetic, would drop or misplace the top bytes when the destination offset is high. One-byte bursts at the extreme offsets target beat-count and enable-mask mistakes, which show up as a stray second beat or as zero or two enable bits. Both banks are filled while the drain side is stalled. This exposes a fill that overwrites a bank still waiting to drain, bursts returned out of order, and output data that moves during a stall. Illegal lengths are presented to show that a design which latches them would start a fill that never ends.

// File: rtl/realign_pkg.sv
package realign_pkg;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_e;

  // Number of bus beats touched by a run of len bytes starting at byte offset off.
  function automatic int beats_spanned(input int off, input int len, input int bytes);
    return (off + len + bytes - 1) / bytes;
  endfunction

endpackage

// File: rtl/rb_lane_map.sv
// Maps each byte lane of the current source beat to its slot in the bank.
module rb_lane_map #(
  parameter int BYTES  = 8,
  parameter int OFF_W  = 3,
  parameter int LEN_W  = 7,
  parameter int POS_W  = 7,
  parameter int BEAT_W = 4
) (
  input  logic [BEAT_W-1:0]            beat_i,
  input  logic [OFF_W-1:0]             src_i,
  input  logic [OFF_W-1:0]             dst_i,
  input  logic [LEN_W-1:0]             len_i,
  output logic [BYTES-1:0]             lane_ok_o,
  output logic [BYTES-1:0][POS_W-1:0]  lane_addr_o
);
  localparam int CW = POS_W + 1;

  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    logic [CW-1:0] pos;
    logic [CW-1:0] rel;
    always_comb begin
      pos            = CW'(beat_i) * CW'(BYTES) + CW'(j);
      rel            = pos - CW'(src_i);
      lane_ok_o[j]   = (pos >= CW'(src_i)) && (rel < CW'(len_i));
      lane_addr_o[j] = POS_W'(rel + CW'(dst_i));
    end
  end

endmodule

// File: rtl/rb_be_gen.sv
// Byte enables of one destination beat.
module rb_be_gen #(
  parameter int BYTES  = 8,
  parameter int OFF_W  = 3,
  parameter int LEN_W  = 7,
  parameter int POS_W  = 7,
  parameter int BEAT_W = 4
) (
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [OFF_W-1:0]  dst_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BYTES-1:0]  be_o
);
  localparam int CW = POS_W + 1;

  logic [CW-1:0] stop;
  assign stop = CW'(dst_i) + CW'(len_i);

  for (genvar j = 0; j < BYTES; j++) begin : g_be
    logic [CW-1:0] pos;
    assign pos     = CW'(beat_i) * CW'(BYTES) + CW'(j);
    assign be_o[j] = (pos >= CW'(dst_i)) && (pos < stop);
  end

endmodule

// File: rtl/rb_bank.sv
// One staging bank: bytes stored at their destination position.
module rb_bank #(
  parameter int BYTES  = 8,
  parameter int DEPTH  = 72,
  parameter int POS_W  = 7,
  parameter int BEAT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [BYTES-1:0]            lane_ok_i,
  input  logic [BYTES-1:0][POS_W-1:0] lane_addr_i,
  input  logic [BYTES*8-1:0]          wr_data_i,
  input  logic [BEAT_W-1:0]           rd_beat_i,
  output logic [BYTES*8-1:0]          rd_data_o
);
  localparam int CW = POS_W + 1;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] mem_d [DEPTH];

  always_comb begin
    mem_d = mem_q;
    for (int j = 0; j < BYTES; j++) begin
      if (lane_ok_i[j] && (CW'(lane_addr_i[j]) < CW'(DEPTH))) begin
        mem_d[lane_addr_i[j]] = wr_data_i[j*8 +: 8];
      end
    end
  end

  // Datapath storage carries no reset; contents matter only once a fill completes.
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q <= mem_d;
    end
  end

  for (genvar j = 0; j < BYTES; j++) begin : g_rd
    logic [CW-1:0] idx;
    assign idx = CW'(rd_beat_i) * CW'(BYTES) + CW'(j);
    assign rd_data_o[j*8 +: 8] = (idx < CW'(DEPTH)) ? mem_q[idx[POS_W-1:0]] : 8'h00;

    // R4: every accepted source byte lands inside the bank
    p_slot_in_range_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && lane_ok_i[j]) |-> (CW'(lane_addr_i[j]) < CW'(DEPTH)));
  end

endmodule

// File: rtl/dw_realign_buf.sv
module dw_realign_buf
  import realign_pkg::*;
#(
  parameter int BYTES     = 8,
  parameter int MAX_BURST = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [$clog2(MAX_BURST+1)-1:0] start_len_i,
  input  logic [$clog2(BYTES)-1:0]     start_src_i,
  input  logic [$clog2(BYTES)-1:0]     start_dst_i,
  output logic                         start_ready_o,
  input  logic                         in_valid_i,
  input  logic [BYTES*8-1:0]           in_data_i,
  output logic                         in_ready_o,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [BYTES*8-1:0]           out_data_o,
  output logic [BYTES-1:0]             out_be_o,
  output logic                         out_last_o,
  output logic [1:0]                   bank_ready_o,
  output logic [1:0]                   bank_empty_o
);
  localparam int OFF_W  = $clog2(BYTES);
  localparam int LEN_W  = $clog2(MAX_BURST + 1);
  localparam int DW     = BYTES * 8;
  localparam int DEPTH  = MAX_BURST + BYTES;
  localparam int POS_W  = $clog2(DEPTH);
  localparam int BEAT_W = $clog2(DEPTH / BYTES + 1);
  localparam int NB     = 2;

  // ---------------- state ----------------
  fill_e                       fill_q, fill_d;
  logic                        wsel_q, wsel_d;
  logic                        rsel_q, rsel_d;
  logic [NB-1:0]               rdy_q, rdy_d;
  logic [BEAT_W-1:0]           ibeat_q, ibeat_d;
  logic [BEAT_W-1:0]           nin_q, nin_d;
  logic [OFF_W-1:0]            src_q, src_d;
  logic [NB-1:0][LEN_W-1:0]    len_q, len_d;
  logic [NB-1:0][OFF_W-1:0]    dst_q, dst_d;
  logic [BEAT_W-1:0]           obeat_q, obeat_d;

  // ---------------- handshakes ----------------
  logic len_ok, start_acc, in_fire, fill_last, out_fire, out_last;
  logic fill_en, drain_en;
  logic [BEAT_W-1:0] nin_new, nout_cur;

  assign len_ok        = (start_len_i != '0) && (int'(start_len_i) <= MAX_BURST);
  assign start_ready_o = (fill_q == FILL_IDLE) && !rdy_q[wsel_q];
  assign start_acc     = start_i && start_ready_o && len_ok;
  assign in_ready_o    = (fill_q == FILL_BUSY);
  assign in_fire       = in_valid_i && in_ready_o;
  assign fill_last     = (ibeat_q == nin_q - BEAT_W'(1));

  assign nin_new  = BEAT_W'(beats_spanned(int'(start_src_i), int'(start_len_i), BYTES));
  assign nout_cur = BEAT_W'(beats_spanned(int'(dst_q[rsel_q]), int'(len_q[rsel_q]), BYTES));

  assign out_valid_o = rdy_q[rsel_q];
  assign out_fire    = out_valid_o && out_ready_i;
  assign out_last    = (obeat_q == nout_cur - BEAT_W'(1));
  assign out_last_o  = out_valid_o && out_last;

  assign fill_en  = start_acc || in_fire;
  assign drain_en = out_fire;

  // ---------------- next state ----------------
  always_comb begin
    fill_d  = fill_q;
    wsel_d  = wsel_q;
    rsel_d  = rsel_q;
    rdy_d   = rdy_q;
    ibeat_d = ibeat_q;
    nin_d   = nin_q;
    src_d   = src_q;
    len_d   = len_q;
    dst_d   = dst_q;
    obeat_d = obeat_q;

    if (start_acc) begin
      fill_d         = FILL_BUSY;
      ibeat_d        = '0;
      nin_d          = nin_new;
      src_d          = start_src_i;
      len_d[wsel_q]  = start_len_i;
      dst_d[wsel_q]  = start_dst_i;
    end

    if (in_fire) begin
      ibeat_d = ibeat_q + BEAT_W'(1);
      if (fill_last) begin
        fill_d        = FILL_IDLE;
        rdy_d[wsel_q] = 1'b1;
        wsel_d        = ~wsel_q;
      end
    end

    if (out_fire) begin
      if (out_last) begin
        obeat_d       = '0;
        rdy_d[rsel_q] = 1'b0;
        rsel_d        = ~rsel_q;
      end else begin
        obeat_d = obeat_q + BEAT_W'(1);
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= FILL_IDLE;
      wsel_q  <= 1'b0;
      ibeat_q <= '0;
      nin_q   <= '0;
      src_q   <= '0;
      len_q   <= '0;
      dst_q   <= '0;
    end else if (fill_en) begin
      fill_q  <= fill_d;
      wsel_q  <= wsel_d;
      ibeat_q <= ibeat_d;
      nin_q   <= nin_d;
      src_q   <= src_d;
      len_q   <= len_d;
      dst_q   <= dst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q  <= 1'b0;
      obeat_q <= '0;
    end else if (drain_en) begin
      rsel_q  <= rsel_d;
      obeat_q <= obeat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
    end else if (fill_en || drain_en) begin
      rdy_q <= rdy_d;
    end
  end

  // ---------------- datapath ----------------
  logic [BYTES-1:0]            lane_ok;
  logic [BYTES-1:0][POS_W-1:0] lane_addr;
  logic [NB-1:0][DW-1:0]       bank_rd;

  rb_lane_map #(
    .BYTES(BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W), .POS_W(POS_W), .BEAT_W(BEAT_W)
  ) u_lane_map (
    .beat_i      (ibeat_q),
    .src_i       (src_q),
    .dst_i       (dst_q[wsel_q]),
    .len_i       (len_q[wsel_q]),
    .lane_ok_o   (lane_ok),
    .lane_addr_o (lane_addr)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic wr_en;
    assign wr_en = in_fire && (wsel_q == 1'(b));
    rb_bank #(
      .BYTES(BYTES), .DEPTH(DEPTH), .POS_W(POS_W), .BEAT_W(BEAT_W)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en),
      .lane_ok_i   (lane_ok),
      .lane_addr_i (lane_addr),
      .wr_data_i   (in_data_i),
      .rd_beat_i   (obeat_q),
      .rd_data_o   (bank_rd[b])
    );
    assign bank_ready_o[b] = rdy_q[b];
    assign bank_empty_o[b] = !rdy_q[b] && !((fill_q == FILL_BUSY) && (wsel_q == 1'(b)));
  end

  rb_be_gen #(
    .BYTES(BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W), .POS_W(POS_W), .BEAT_W(BEAT_W)
  ) u_be_gen (
    .beat_i (obeat_q),
    .dst_i  (dst_q[rsel_q]),
    .len_i  (len_q[rsel_q]),
    .be_o   (out_be_o)
  );

  assign out_data_o = bank_rd[rsel_q];

  // ---------------- assertions ----------------
  // R3: an illegal length never starts a fill
  p_bad_len_ignored_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !len_ok && fill_q == FILL_IDLE) |=> (fill_q == FILL_IDLE));

  // R6: a presented beat always enables at least one byte
  p_be_nonzero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_be_o != '0));

  // R6: the first beat starts exactly at the destination lane
  p_first_be_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && obeat_q == '0) |->
      (out_be_o[dst_q[rsel_q]] && ((out_be_o & ~({BYTES{1'b1}} << dst_q[rsel_q])) == '0)));

  // R7: a single-byte burst is one beat with one enable
  p_single_byte_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && len_q[rsel_q] == LEN_W'(1)) |-> (out_last_o && $countones(out_be_o) == 1));

  // R8: completing a fill marks that bank ready
  p_ready_after_fill_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && fill_last) |=> bank_ready_o[$past(wsel_q)]);

  // R9: the fill side never writes into a bank awaiting drain
  p_no_fill_into_ready_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> !rdy_q[wsel_q]);

  // R10: drain side alternates after every completed burst
  p_drain_toggle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> (rsel_q != $past(rsel_q)));

  // R11: a stalled beat holds still
  p_stall_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_be_o)));

endmodule

// File: tb/tb_dw_realign_buf.sv
module tb_dw_realign_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  s_len = '0;
  logic [2:0]  s_src = '0;
  logic [2:0]  s_dst = '0;
  logic        start_ready;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic [7:0]  out_be;
  logic        out_last;
  logic [1:0]  bank_ready;
  logic [1:0]  bank_empty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdy_mode = 1;      // 0 low, 1 high, 2 random
  int r7_beats = 0;
  int r7_ones = 0;

  always #10 clk = ~clk;  // 50 MHz

  dw_realign_buf dut (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .start_len_i(s_len), .start_src_i(s_src), .start_dst_i(s_dst),
    .start_ready_o(start_ready),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_be_o(out_be), .out_last_o(out_last),
    .bank_ready_o(bank_ready), .bank_empty_o(bank_empty)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // ---------------- behavioural reference ----------------
  bit         m_filling;
  bit         m_wsel, m_rsel;
  bit [1:0]   m_rdy;
  int         m_ibeat, m_nin, m_src, m_obeat;
  int         m_len [2];
  int         m_dst [2];
  logic [7:0] q0 [$];
  logic [7:0] q1 [$];

  function automatic logic [7:0] qbyte(input bit bank, input int idx);
    return bank ? q1[idx] : q0[idx];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_filling = 0; m_wsel = 0; m_rsel = 0; m_rdy = 0;
      m_ibeat = 0; m_nin = 0; m_src = 0; m_obeat = 0;
      m_len[0] = 0; m_len[1] = 0; m_dst[0] = 0; m_dst[1] = 0;
      q0.delete(); q1.delete();
    end else begin
      bit acc, infire, outfire, olast;
      acc     = start && !m_filling && !m_rdy[m_wsel] && s_len >= 1 && s_len <= 64;
      infire  = in_valid && m_filling;
      outfire = m_rdy[m_rsel] && out_ready;
      olast   = outfire && (m_obeat == (m_dst[m_rsel] + m_len[m_rsel] + 7) / 8 - 1);
      if (acc) begin
        m_filling = 1; m_ibeat = 0; m_src = int'(s_src);
        m_nin = (int'(s_src) + int'(s_len) + 7) / 8;
        m_len[m_wsel] = int'(s_len); m_dst[m_wsel] = int'(s_dst);
        if (m_wsel) q1.delete(); else q0.delete();
      end
      if (infire) begin
        for (int j = 0; j < 8; j++) begin
          int k;
          k = m_ibeat * 8 + j - m_src;
          if (k >= 0 && k < m_len[m_wsel]) begin
            if (m_wsel) q1.push_back(in_data[j*8 +: 8]); else q0.push_back(in_data[j*8 +: 8]);
          end
        end
        m_ibeat++;
        if (m_ibeat == m_nin) begin
          m_filling = 0; m_rdy[m_wsel] = 1; m_wsel = ~m_wsel;
        end
      end
      if (outfire) begin
        if (olast) begin
          m_rdy[m_rsel] = 0; m_rsel = ~m_rsel; m_obeat = 0;
        end else m_obeat++;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      logic [1:0] exp_empty;
      exp_empty[0] = !m_rdy[0] && !(m_filling && m_wsel == 1'b0);
      exp_empty[1] = !m_rdy[1] && !(m_filling && m_wsel == 1'b1);
      chk(start_ready == (!m_filling && !m_rdy[m_wsel]), "R9 start_ready", 64'(start_ready), 64'(!m_filling && !m_rdy[m_wsel]));
      chk(in_ready == m_filling, "R2 in_ready", 64'(in_ready), 64'(m_filling));
      chk(bank_ready == m_rdy, "R8 bank_ready", 64'(bank_ready), 64'(m_rdy));
      chk(out_valid == m_rdy[m_rsel], "R8 out_valid", 64'(out_valid), 64'(m_rdy[m_rsel]));
      chk(bank_empty == exp_empty, "R12 bank_empty", 64'(bank_empty), 64'(exp_empty));
      if (out_valid && m_rdy[m_rsel]) begin
        logic [7:0]  ebe;
        logic [63:0] edata, mask;
        int d, l, nout;
        d = m_dst[m_rsel]; l = m_len[m_rsel]; nout = (d + l + 7) / 8;
        ebe = '0; edata = '0; mask = '0;
        for (int j = 0; j < 8; j++) begin
          int pos;
          pos = m_obeat * 8 + j;
          if (pos >= d && pos < d + l) begin
            ebe[j] = 1'b1;
            mask[j*8 +: 8] = 8'hff;
            edata[j*8 +: 8] = qbyte(m_rsel, pos - d);
          end
        end
        chk(out_be == ebe, "R6 out_be", 64'(out_be), 64'(ebe));
        chk(out_last == (m_obeat == nout - 1), "R5 out_last", 64'(out_last), 64'(m_obeat == nout - 1));
        chk((out_data & mask) == edata, "R4/R10 out_data", out_data & mask, edata);
        if (out_ready) begin
          r7_beats++;
          r7_ones += $countones(out_be);
        end
      end
    end
  end

  // ---------------- drivers ----------------
  always @(negedge clk) begin
    case (rdy_mode)
      0:       out_ready = 1'b0;
      1:       out_ready = 1'b1;
      default: out_ready = ($urandom % 4) != 0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
      $finish;
    end
  end

  task automatic run_burst(input int src, input int dst, input int len, input bit gaps);
    int nin;
    nin = (src + len + 7) / 8;
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start = 1'b1; s_src = 3'(src); s_dst = 3'(dst); s_len = 7'(len);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nin; ) begin
      if (gaps && ($urandom % 3) == 0) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data = {$urandom, $urandom};
        i++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain_all();
    @(negedge clk);
    while (m_filling || m_rdy != 2'b00) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b0, "R1 in_ready", 64'(in_ready), 64'd0);
    chk(start_ready == 1'b1, "R1 start_ready", 64'(start_ready), 64'd1);
    chk(bank_ready == 2'b00, "R1 bank_ready", 64'(bank_ready), 64'd0);
    chk(bank_empty == 2'b11, "R1 bank_empty", 64'(bank_empty), 64'd3);

    // R3 illegal lengths
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      start = 1'b1; s_len = (t == 0) ? 7'd0 : 7'd65; s_src = 3'd2; s_dst = 3'd5;
      @(negedge clk);
      start = 1'b0;
      chk(in_ready == 1'b0, "R3 in_ready after bad length", 64'(in_ready), 64'd0);
      chk(start_ready == 1'b1, "R3 start_ready after bad length", 64'(start_ready), 64'd1);
      chk(bank_empty == 2'b11, "R3 bank_empty after bad length", 64'(bank_empty), 64'd3);
    end

    // R7 single-byte bursts at extreme offsets
    rdy_mode = 1;
    for (int t = 0; t < 6; t++) begin
      int sv, dv;
      sv = (t == 0) ? 0 : (t == 1) ? 7 : (t == 2) ? 0 : (t == 3) ? 7 : (t == 4) ? 3 : 6;
      dv = (t == 0) ? 0 : (t == 1) ? 7 : (t == 2) ? 7 : (t == 3) ? 0 : (t == 4) ? 5 : 1;
      drain_all();
      r7_beats = 0; r7_ones = 0;
      run_burst(sv, dv, 1, 1'b0);
      drain_all();
      chk(r7_beats == 1, "R7 beat count", 64'(r7_beats), 64'd1);
      chk(r7_ones == 1, "R7 enable count", 64'(r7_ones), 64'd1);
    end

    // R9 / R11: fill both banks with the drain side stalled
    drain_all();
    rdy_mode = 0;
    run_burst(5, 2, 20, 1'b0);
    @(negedge clk);
    chk(start_ready == 1'b1, "R9 second bank free", 64'(start_ready), 64'd1);
    chk(bank_ready == 2'b01, "R8 first bank ready", 64'(bank_ready), 64'd1);
    run_burst(1, 6, 64, 1'b1);
    @(negedge clk);
    chk(start_ready == 1'b0, "R9 both banks held", 64'(start_ready), 64'd0);
    chk(bank_ready == 2'b11, "R8 both banks ready", 64'(bank_ready), 64'd3);
    begin
      logic [63:0] d0;
      logic [7:0]  b0;
      d0 = out_data; b0 = out_be;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b1, "R11 valid held", 64'(out_valid), 64'd1);
      chk(out_data == d0, "R11 data held", out_data, d0);
      chk(out_be == b0, "R11 be held", 64'(out_be), 64'(b0));
    end
    rdy_mode = 2;
    drain_all();

    // R4 R5 R6: every offset pair at full length, drain running concurrently
    for (int sv = 0; sv < 8; sv++) begin
      for (int dv = 0; dv < 8; dv++) begin
        run_burst(sv, dv, 64, (sv + dv) % 2 == 1);
      end
    end
    drain_all();

    // R2 R10: random lengths and offsets, random stalls
    for (int t = 0; t < 60; t++) begin
      run_burst(int'($urandom % 8), int'($urandom % 8), 1 + int'($urandom % 64), 1'b1);
    end
    drain_all();

    rdy_mode = 1;
    repeat (4) @(negedge clk);
    report();
    $finish;
  end

endmodule